// File: doc/BRIEF.md
# Data Pointer Address Modifier

This block holds the two address pointers of a small signal-processing core. One is an 8-bit pointer into data RAM. The other is an 11-bit pointer into coefficient ROM. Each operation instruction can adjust both pointers, and the adjustment is cheap by design. The low nibble of the RAM pointer steps up or down, wrapping inside its own four bits, or it is cleared. The upper part of the RAM pointer is flipped by a 4-bit XOR mask. The ROM pointer can count down by one.

A pointer can also be loaded in the same cycle. In that case the adjustment acts on the freshly loaded value, not on the old one. When `op_valid` is low, only loads take effect and the adjustment fields are ignored.

The block gives the RAM address as it stands. It also gives a second RAM address with bit 6 forced high, which is used to fetch a coefficient from the upper half of the RAM. Two status lines report whether the low nibble of the RAM pointer is 0 or 15, so that loop branches can test them. The memory arrays sit outside this block.

Top module: `dp_addr_mod`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dp` and `rp` both read zero until the first update.
- R2: With `op_valid` high and `lo_mode` = 1, `dp[3:0]` increments modulo 16 (15 becomes 0). There is no carry into `dp[7:4]` apart from the XOR mask.
- R3: With `op_valid` high and `lo_mode` = 2, `dp[3:0]` decrements modulo 16 (0 becomes 15). There is no borrow out of `dp[3:0]`.
- R4: With `op_valid` high, `lo_mode` = 3 clears `dp[3:0]` and `lo_mode` = 0 leaves it unchanged.
- R5: With `op_valid` high, `dp[7:4]` becomes its prior value XOR `hi_mask`, and this is applied after the low-nibble step of the same cycle.
- R6: With `op_valid` and `rp_dec` high, `rp` decreases by one, and 0 wraps to 2047.
- R7: A load (`dp_load`/`dp_load_val`, `rp_load`/`rp_load_val`) in the same cycle as an operation is applied first, and the modification then acts on the loaded value.
- R8: With `op_valid` low, `lo_mode`, `hi_mask` and `rp_dec` have no effect. Pointers change only by loads.
- R9: `ram_addr` equals `dp`. `coef_addr` equals `dp` with bit 6 forced to 1.
- R10: `lo_is_zero` is high exactly when `dp[3:0]` = 0, and `lo_is_max` is high exactly when `dp[3:0]` = 15. Both follow the registered `dp` with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation instruction applies its pointer modification this cycle |
| lo_mode | input | 2 | Low-nibble action: 0 hold, 1 increment, 2 decrement, 3 clear |
| hi_mask | input | 4 | XOR mask for `dp[7:4]` |
| rp_dec | input | 1 | Decrement `rp` |
| dp_load | input | 1 | Load `dp` from `dp_load_val` |
| dp_load_val | input | 8 | Load value for `dp` |
| rp_load | input | 1 | Load `rp` from `rp_load_val` |
| rp_load_val | input | 11 | Load value for `rp` |
| dp | output | 8 | Current data-RAM pointer |
| rp | output | 11 | Current coefficient-ROM pointer |
| ram_addr | output | 8 | Address for the normal RAM access |
| coef_addr | output | 8 | RAM address with bit 6 set, for the coefficient fetch |
| lo_is_zero | output | 1 | `dp[3:0]` is 0 |
| lo_is_max | output | 1 | `dp[3:0]` is 15 |

## Verification
A load and a modification can fall in the same cycle, and their order decides the result. The bench provokes this by pulsing `dp_load` or `rp_load` together with `op_valid` and a non-zero step, mask or decrement. Examples are loading 0x3F with increment and mask 5, and loading 0 into the ROM pointer with decrement. The result is judged against the value obtained by applying the step to the loaded value, which differs from both the raw load and the step applied to the old value.

// File: rtl/dp_addr_mod.sv
module dp_addr_mod #(
  parameter int DP_W    = 8,
  parameter int RP_W    = 11,
  parameter int LO_W    = 4,
  parameter int ALT_BIT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      lo_mode,
  input  logic [DP_W-LO_W-1:0] hi_mask,
  input  logic            rp_dec,
  input  logic            dp_load,
  input  logic [DP_W-1:0] dp_load_val,
  input  logic            rp_load,
  input  logic [RP_W-1:0] rp_load_val,
  output logic [DP_W-1:0] dp,
  output logic [RP_W-1:0] rp,
  output logic [DP_W-1:0] ram_addr,
  output logic [DP_W-1:0] coef_addr,
  output logic            lo_is_zero,
  output logic            lo_is_max
);
  localparam int HI_W = DP_W - LO_W;

  logic [DP_W-1:0] dp_q, dp_base, dp_next;
  logic [RP_W-1:0] rp_q, rp_base, rp_next;
  logic [LO_W-1:0] lo_next;
  logic [HI_W-1:0] hi_next;

  assign dp_base = dp_load ? dp_load_val : dp_q;
  assign rp_base = rp_load ? rp_load_val : rp_q;

  always_comb begin
    unique case (lo_mode)
      2'd1:    lo_next = dp_base[LO_W-1:0] + 1'b1;
      2'd2:    lo_next = dp_base[LO_W-1:0] - 1'b1;
      2'd3:    lo_next = '0;
      default: lo_next = dp_base[LO_W-1:0];
    endcase
    hi_next = dp_base[DP_W-1:LO_W] ^ hi_mask;
    dp_next = dp_base;
    rp_next = rp_base;
    if (op_valid) begin
      dp_next = {hi_next, lo_next};
      if (rp_dec) rp_next = rp_base - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_q <= '0;
      rp_q <= '0;
    end else begin
      dp_q <= dp_next;
      rp_q <= rp_next;
    end
  end

  assign dp         = dp_q;
  assign rp         = rp_q;
  assign ram_addr   = dp_q;
  assign coef_addr  = dp_q | (DP_W'(1) << ALT_BIT);
  assign lo_is_zero = (dp_q[LO_W-1:0] == '0);
  assign lo_is_max  = &dp_q[LO_W-1:0];
endmodule

// File: rtl/dp_addr_mod_chk.sv
module dp_addr_mod_chk #(
  parameter int DP_W    = 8,
  parameter int RP_W    = 11,
  parameter int LO_W    = 4,
  parameter int ALT_BIT = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [1:0]      lo_mode,
  input logic [DP_W-LO_W-1:0] hi_mask,
  input logic            rp_dec,
  input logic            dp_load,
  input logic [DP_W-1:0] dp_load_val,
  input logic            rp_load,
  input logic [RP_W-1:0] rp_load_val,
  input logic [DP_W-1:0] dp,
  input logic [RP_W-1:0] rp,
  input logic [DP_W-1:0] ram_addr,
  input logic [DP_W-1:0] coef_addr,
  input logic            lo_is_zero,
  input logic            lo_is_max
);
  a_r2_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lo_mode == 2'd1 && !dp_load) |=>
      dp[LO_W-1:0] == LO_W'($past(dp[LO_W-1:0]) + 1'b1));

  a_r3_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lo_mode == 2'd2 && !dp_load) |=>
      dp[LO_W-1:0] == LO_W'($past(dp[LO_W-1:0]) - 1'b1));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lo_mode == 2'd3) |=> lo_is_zero);

  a_r5_upper_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dp_load) |=>
      dp[DP_W-1:LO_W] == ($past(dp[DP_W-1:LO_W]) ^ $past(hi_mask)));

  a_r6_rp_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && rp_dec && !rp_load) |=> rp == RP_W'($past(rp) - 1'b1));

  a_r7_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && dp_load) |=> dp == $past(dp_load_val));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !dp_load && !rp_load) |=> ($stable(dp) && $stable(rp)));

  a_r9_alt_addr: assert property (@(posedge clk) disable iff (!rst_n)
    coef_addr[ALT_BIT] && ram_addr == dp);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_is_zero, lo_is_max}));
endmodule

bind dp_addr_mod dp_addr_mod_chk #(
  .DP_W(DP_W), .RP_W(RP_W), .LO_W(LO_W), .ALT_BIT(ALT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .lo_mode(lo_mode),
  .hi_mask(hi_mask), .rp_dec(rp_dec), .dp_load(dp_load),
  .dp_load_val(dp_load_val), .rp_load(rp_load), .rp_load_val(rp_load_val),
  .dp(dp), .rp(rp), .ram_addr(ram_addr), .coef_addr(coef_addr),
  .lo_is_zero(lo_is_zero), .lo_is_max(lo_is_max)
);

// File: tb/test_dp_addr_mod.sv
module test_dp_addr_mod;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  lo_mode;
  logic [3:0]  hi_mask;
  logic        rp_dec;
  logic        dp_load;
  logic [7:0]  dp_load_val;
  logic        rp_load;
  logic [10:0] rp_load_val;
  logic [7:0]  dp, ram_addr, coef_addr;
  logic [10:0] rp;
  logic        lo_is_zero, lo_is_max;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_addr_mod i_dp_addr_mod (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .lo_mode(lo_mode),
    .hi_mask(hi_mask), .rp_dec(rp_dec), .dp_load(dp_load),
    .dp_load_val(dp_load_val), .rp_load(rp_load), .rp_load_val(rp_load_val),
    .dp(dp), .rp(rp), .ram_addr(ram_addr), .coef_addr(coef_addr),
    .lo_is_zero(lo_is_zero), .lo_is_max(lo_is_max)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; lo_mode = 0; hi_mask = 0; rp_dec = 0;
    dp_load = 0; dp_load_val = 0; rp_load = 0; rp_load_val = 0;
  endtask

  // one cycle: inputs set at negedge, results read at the next negedge
  task automatic cycle(input logic op, input logic [1:0] mode, input logic [3:0] mask,
                       input logic dec, input logic dl, input logic [7:0] dv,
                       input logic rl, input logic [10:0] rv);
    op_valid = op; lo_mode = mode; hi_mask = mask; rp_dec = dec;
    dp_load = dl; dp_load_val = dv; rp_load = rl; rp_load_val = rv;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic load_dp(input logic [7:0] v);
    cycle(0, 0, 0, 0, 1, v, 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle_inputs();
    op_valid = 1; lo_mode = 1; hi_mask = 4'hF; rp_dec = 1;
    repeat (3) @(negedge clk);
    check("R1", "dp in reset", dp, 0);
    check("R1", "rp in reset", rp, 0);
    idle_inputs();
    rst_n = 1;
    @(negedge clk);
    check("R1", "dp after reset", dp, 0);
    check("R1", "rp after reset", rp, 0);
  endtask

  task automatic t_increment();
    load_dp(8'h3D);
    cycle(1, 1, 0, 0, 0, 0, 0, 0);
    check("R2", "inc 3D", dp, 8'h3E);
    cycle(1, 1, 0, 0, 0, 0, 0, 0);
    check("R2", "inc to F", dp, 8'h3F);
    check("R10", "max flag", lo_is_max, 1);
    check("R10", "zero flag off", lo_is_zero, 0);
    cycle(1, 1, 0, 0, 0, 0, 0, 0);
    check("R2", "inc wraps in nibble", dp, 8'h30);
    check("R10", "zero flag", lo_is_zero, 1);
    check("R10", "max flag off", lo_is_max, 0);
  endtask

  task automatic t_decrement();
    load_dp(8'h20);
    cycle(1, 2, 0, 0, 0, 0, 0, 0);
    check("R3", "dec wraps in nibble", dp, 8'h2F);
    cycle(1, 2, 0, 0, 0, 0, 0, 0);
    check("R3", "dec 2F", dp, 8'h2E);
  endtask

  task automatic t_clear_hold();
    load_dp(8'hA7);
    cycle(1, 0, 0, 0, 0, 0, 0, 0);
    check("R4", "mode 0 holds", dp, 8'hA7);
    cycle(1, 3, 0, 0, 0, 0, 0, 0);
    check("R4", "mode 3 clears", dp, 8'hA0);
  endtask

  task automatic t_xor();
    load_dp(8'hA7);
    cycle(1, 3, 4'hF, 0, 0, 0, 0, 0);
    check("R5", "clear plus mask F", dp, 8'h50);
    cycle(1, 2, 4'h3, 0, 0, 0, 0, 0);
    check("R5", "dec plus mask 3", dp, 8'h6F);
    cycle(1, 1, 4'h6, 0, 0, 0, 0, 0);
    check("R5", "inc wrap no carry, mask 6", dp, 8'h00);
  endtask

  task automatic t_rp();
    cycle(0, 0, 0, 0, 0, 0, 1, 11'd5);
    check("R6", "rp load", rp, 5);
    cycle(1, 0, 0, 1, 0, 0, 0, 0);
    check("R6", "rp dec", rp, 4);
    cycle(1, 0, 0, 0, 0, 0, 0, 0);
    check("R6", "rp no dec bit", rp, 4);
    cycle(0, 0, 0, 0, 0, 0, 1, 11'd0);
    cycle(1, 0, 0, 1, 0, 0, 0, 0);
    check("R6", "rp wraps", rp, 11'h7FF);
  endtask

  task automatic t_load_then_modify();
    load_dp(8'h11);
    cycle(1, 1, 4'h5, 0, 1, 8'h3F, 0, 0);
    check("R7", "dp load then inc+mask", dp, 8'h60);
    cycle(1, 2, 4'h0, 1, 1, 8'h80, 1, 11'd0);
    check("R7", "dp load then dec", dp, 8'h8F);
    check("R7", "rp load then dec", rp, 11'h7FF);
  endtask

  task automatic t_ignored();
    load_dp(8'h42);
    cycle(0, 0, 0, 0, 0, 0, 1, 11'd9);
    cycle(0, 1, 4'hF, 1, 0, 0, 0, 0);
    check("R8", "dp unchanged", dp, 8'h42);
    check("R8", "rp unchanged", rp, 9);
    cycle(0, 3, 4'hA, 1, 1, 8'h77, 0, 0);
    check("R8", "plain load only", dp, 8'h77);
    check("R8", "rp unchanged after load", rp, 9);
  endtask

  task automatic t_addr();
    load_dp(8'h25);
    check("R9", "ram_addr", ram_addr, 8'h25);
    check("R9", "coef_addr", coef_addr, 8'h65);
    load_dp(8'hC3);
    check("R9", "coef_addr bit already set", coef_addr, 8'hC3);
    check("R9", "ram_addr 2", ram_addr, 8'hC3);
    check("R10", "neither flag", {lo_is_zero, lo_is_max}, 0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    t_reset();
    t_increment();
    t_decrement();
    t_clear_hold();
    t_xor();
    t_rp();
    t_load_then_modify();
    t_ignored();
    t_addr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule